// File: doc/BRIEF.md
# Serial-Loaded LCD Segment Driver

This block receives display data from a host over a three-wire serial link (data, shift strobe, load strobe). Bits enter a long shift chain split into two equal halves. A load strobe copies the chain into two holding latches. From the latches the block produces one digital drive code per segment and two backplane (common) drive codes. It supports two modes. In static mode one latch drives every segment. In half-duty mode the two latches share the segment outputs in time, one half per common. The block does not generate analog levels. Each output is a logic level, and each common output is a two-bit tri-level code.

The common-frame timing comes from a reference tick. The tick is either an external enable or an internal divider of the system clock. It is divided by 64 or by 128. Each division step advances a four-state phase counter. A sync output marks the first phase in half-duty mode. A device set as slave realigns its phase on a rising sync input, so chained devices stay in step. The serial data, shift strobe, load strobe, all-on and all-off inputs are passed on to the next device in a chain. All-off takes precedence over all-on. Both act on the outputs only and never on the latched data.

The serial link is sampled in the system clock domain. `shift_en` and `load_in` are single-cycle enables, and all outputs are registered.

Top module: `seg_lcd_driver`

## Requirements
- R1: Each cycle with `shift_en` high shifts `ser_in` into stage 0 of a 2*HALF stage chain, with every stage moving up one place. `ser_out` is the top stage, so a bit appears on `ser_out` after exactly 2*HALF shifts. Reset clears the chain, so `ser_out` is 0.
- R2: On `load_in`, latch A bit i takes chain stage i and latch B bit i takes chain stage HALF+i. Shifting without a load leaves the segment outputs unchanged.
- R3: `shift_out`, `load_out`, `test_out` and `blank_out` equal `shift_en`, `load_in`, `test_in` and `blank_in`, delayed by one clock.
- R4: The phase advances once per 64 reference ticks when `div_sel`=0 and once per 128 when `div_sel`=1. With `osc_sel`=0 the reference tick is `ext_tick`. With `osc_sel`=1 it is an internal tick every INT_DIV clocks.
- R5: Common codes are LOW=2'b00, MID=2'b01 and HIGH=2'b10. In static mode (`duty_mode`=0), `com_a` equals `com_b`. The commons are HIGH when polarity is 1 and LOW when it is 0. Polarity alternates on every phase step. `seg_out[i]` = latch A bit i XOR polarity.
- R6: In half-duty mode the common state follows the cycle (A LOW) → (A HIGH) → (B LOW) → (B HIGH) → repeat. The selected common carries the level, and the other common is MID.
- R7: In half-duty mode, `seg_out[i]` = (latch A bit i when `com_a` is selected, latch B bit i when `com_b` is selected) XOR polarity. Polarity is 1 exactly when the selected common is HIGH.
- R8: With `test_in` high and `blank_in` low, every `seg_out` bit equals NOT polarity (all on).
- R9: With `blank_in` high, every `seg_out` bit equals polarity (all off), whatever the value of `test_in`. Releasing both overrides restores the latched data.
- R10: `sync_out` is high only in half-duty mode, exactly while the common state is (A LOW). It is low in static mode.
- R11: With `slave_mode`=1, a rising edge on `sync_in` returns the phase to (A LOW) and restarts the divider, so the next step comes a full division later. With `slave_mode`=0, `sync_in` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Serial shift strobe (one per bit) |
| ser_in | input | 1 | Serial display data |
| load_in | input | 1 | Latch transfer strobe |
| duty_mode | input | 1 | 0 static, 1 half-duty |
| div_sel | input | 1 | 0 divide by 64, 1 divide by 128 |
| osc_sel | input | 1 | 0 external tick, 1 internal tick |
| slave_mode | input | 1 | 1 follows incoming sync |
| ext_tick | input | 1 | External reference tick enable |
| sync_in | input | 1 | Frame sync from a master device |
| blank_in | input | 1 | Force all segments off |
| test_in | input | 1 | Force all segments on |
| seg_out | output | HALF | Segment drive levels |
| com_a | output | 2 | Common A tri-level code |
| com_b | output | 2 | Common B tri-level code |
| sync_out | output | 1 | Frame sync pulse |
| ser_out | output | 1 | Serial data to next device |
| shift_out | output | 1 | Shift strobe to next device |
| load_out | output | 1 | Load strobe to next device |
| blank_out | output | 1 | Blank to next device |
| test_out | output | 1 | Test to next device |

## Verification
The bench shifts 640 random bits and compares `ser_out` after every shift. An off-by-one chain length would move the pattern by a bit, and a missing reset would give unknown leading bits. It steps through every phase in both modes and checks each common state against the cycle order and each segment against the latch half selected. A swapped half or an inverted polarity breaks the zero-DC drive and shows as wrong segment bits. It checks the phase spacing for both divisors and for the internal tick, as well as a slave realignment on sync and a master that must ignore sync. Random combinations of blank and test catch a wrong precedence or an override that corrupts the latch.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_t;
endpackage

// File: rtl/lcdseg_shift_chain.sv
module lcdseg_shift_chain #(
  parameter int HALF = 160
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            ser_in,
  input  logic            load_in,
  output logic [HALF-1:0] lat_a,
  output logic [HALF-1:0] lat_b,
  output logic            ser_out
);
  localparam int TOTAL = 2 * HALF;

  logic [TOTAL-1:0] chain;

  // stage 0 receives the new bit; the top stage feeds the next device
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else if (shift_en) chain <= {chain[TOTAL-2:0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_a <= '0;
      lat_b <= '0;
    end else if (load_in) begin
      lat_a <= chain[HALF-1:0];
      lat_b <= chain[TOTAL-1:HALF];
    end
  end

  assign ser_out = chain[TOTAL-1];
endmodule

// File: rtl/lcdseg_frame_timer.sv
module lcdseg_frame_timer #(
  parameter int INT_DIV = 4,
  parameter int DIV_LOG = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_sel,
  input  logic       ext_tick,
  input  logic       div_sel,
  input  logic       slave_mode,
  input  logic       sync_in,
  output logic [1:0] phase
);
  localparam int IW    = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam int PW    = DIV_LOG + 1;
  localparam logic [PW-1:0] LIM_SHORT = PW'((1 << DIV_LOG) - 1);
  localparam logic [PW-1:0] LIM_LONG  = PW'((1 << PW) - 1);

  logic [IW-1:0] icnt;
  logic          int_tick;
  logic          ref_tick;
  logic [PW-1:0] pre;
  logic [PW-1:0] limit;
  logic          sync_q;
  logic          sync_rise;

  assign int_tick  = (icnt == IW'(INT_DIV - 1));
  assign ref_tick  = osc_sel ? int_tick : ext_tick;
  assign limit     = div_sel ? LIM_LONG : LIM_SHORT;
  assign sync_rise = sync_in & ~sync_q;

  always_ff @(posedge clk) begin
    if (rst) icnt <= '0;
    else if (int_tick) icnt <= '0;
    else icnt <= icnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else sync_q <= sync_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre   <= '0;
      phase <= '0;
    end else if (slave_mode && sync_rise) begin
      pre   <= '0;
      phase <= '0;
    end else if (ref_tick) begin
      if (pre == limit) begin
        pre   <= '0;
        phase <= phase + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcdseg_drive_out.sv
module lcdseg_drive_out
  import lcdseg_pkg::*;
#(
  parameter int HALF = 160
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      phase,
  input  logic            duty_mode,
  input  logic            blank_in,
  input  logic            test_in,
  input  logic [HALF-1:0] lat_a,
  input  logic [HALF-1:0] lat_b,
  output logic [HALF-1:0] seg_out,
  output logic [1:0]      com_a,
  output logic [1:0]      com_b,
  output logic            sync_out
);
  logic            pol;
  logic            use_b;
  logic [HALF-1:0] seg_nxt;
  lvl_t            lvl_sel;
  lvl_t            com_a_nxt;
  lvl_t            com_b_nxt;

  assign pol     = phase[0];
  assign use_b   = duty_mode & phase[1];
  assign lvl_sel = pol ? LVL_HIGH : LVL_LOW;

  for (genvar i = 0; i < HALF; i++) begin : g_seg
    logic bit_data;
    logic bit_forced;
    always_comb begin
      bit_data   = use_b ? lat_b[i] : lat_a[i];
      bit_forced = blank_in ? 1'b0 : (test_in ? 1'b1 : bit_data);
      seg_nxt[i] = bit_forced ^ pol;
    end
  end

  always_comb begin
    if (!duty_mode) begin
      com_a_nxt = lvl_sel;
      com_b_nxt = lvl_sel;
    end else if (phase[1]) begin
      com_a_nxt = LVL_MID;
      com_b_nxt = lvl_sel;
    end else begin
      com_a_nxt = lvl_sel;
      com_b_nxt = LVL_MID;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_out  <= '0;
      com_a    <= LVL_LOW;
      com_b    <= LVL_LOW;
      sync_out <= 1'b0;
    end else begin
      seg_out  <= seg_nxt;
      com_a    <= com_a_nxt;
      com_b    <= com_b_nxt;
      sync_out <= duty_mode && (phase == 2'd0);
    end
  end
endmodule

// File: rtl/seg_lcd_driver.sv
module seg_lcd_driver #(
  parameter int HALF    = 160,
  parameter int INT_DIV = 4,
  parameter int DIV_LOG = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            ser_in,
  input  logic            load_in,
  input  logic            duty_mode,
  input  logic            div_sel,
  input  logic            osc_sel,
  input  logic            slave_mode,
  input  logic            ext_tick,
  input  logic            sync_in,
  input  logic            blank_in,
  input  logic            test_in,
  output logic [HALF-1:0] seg_out,
  output logic [1:0]      com_a,
  output logic [1:0]      com_b,
  output logic            sync_out,
  output logic            ser_out,
  output logic            shift_out,
  output logic            load_out,
  output logic            blank_out,
  output logic            test_out
);
  logic [HALF-1:0] lat_a;
  logic [HALF-1:0] lat_b;
  logic [1:0]      phase;

  lcdseg_shift_chain #(.HALF(HALF)) u_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .load_in(load_in), .lat_a(lat_a), .lat_b(lat_b), .ser_out(ser_out)
  );

  lcdseg_frame_timer #(.INT_DIV(INT_DIV), .DIV_LOG(DIV_LOG)) u_timer (
    .clk(clk), .rst(rst), .osc_sel(osc_sel), .ext_tick(ext_tick),
    .div_sel(div_sel), .slave_mode(slave_mode), .sync_in(sync_in),
    .phase(phase)
  );

  lcdseg_drive_out #(.HALF(HALF)) u_drive (
    .clk(clk), .rst(rst), .phase(phase), .duty_mode(duty_mode),
    .blank_in(blank_in), .test_in(test_in), .lat_a(lat_a), .lat_b(lat_b),
    .seg_out(seg_out), .com_a(com_a), .com_b(com_b), .sync_out(sync_out)
  );

  // cascade repeaters, one register each
  always_ff @(posedge clk) begin
    if (rst) begin
      shift_out <= 1'b0;
      load_out  <= 1'b0;
      blank_out <= 1'b0;
      test_out  <= 1'b0;
    end else begin
      shift_out <= shift_en;
      load_out  <= load_in;
      blank_out <= blank_in;
      test_out  <= test_in;
    end
  end
endmodule

// File: rtl/lcdseg_checker.sv
module lcdseg_checker #(
  parameter int HALF = 160
) (
  input logic            clk,
  input logic            rst,
  input logic            shift_en,
  input logic            load_in,
  input logic            duty_mode,
  input logic            blank_in,
  input logic            test_in,
  input logic [HALF-1:0] seg_out,
  input logic [1:0]      com_a,
  input logic [1:0]      com_b,
  input logic            sync_out,
  input logic            ser_out,
  input logic            load_out
);
  localparam logic [1:0] C_LOW  = 2'b00;
  localparam logic [1:0] C_MID  = 2'b01;
  localparam logic [1:0] C_HIGH = 2'b10;

  logic pol_w;
  assign pol_w = (com_a == C_HIGH) || (com_b == C_HIGH);

  assert_hold_sdo_R1: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(ser_out));

  assert_load_fwd_R3: assert property (@(posedge clk) disable iff (rst)
    load_in |=> load_out);

  assert_static_com_R5: assert property (@(posedge clk) disable iff (rst)
    !duty_mode |=> (com_a == com_b) && (com_a != C_MID));

  assert_duty_one_mid_R6: assert property (@(posedge clk) disable iff (rst)
    duty_mode |=> ((com_a == C_MID) != (com_b == C_MID)));

  assert_test_on_R8: assert property (@(posedge clk) disable iff (rst)
    (test_in && !blank_in) |=> (seg_out == {HALF{~pol_w}}));

  assert_blank_off_R9: assert property (@(posedge clk) disable iff (rst)
    blank_in |=> (seg_out == {HALF{pol_w}}));

  assert_sync_phase_R10: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> (com_a == C_LOW) && (com_b == C_MID));
endmodule

bind seg_lcd_driver lcdseg_checker #(.HALF(HALF)) u_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .load_in(load_in),
  .duty_mode(duty_mode), .blank_in(blank_in), .test_in(test_in),
  .seg_out(seg_out), .com_a(com_a), .com_b(com_b), .sync_out(sync_out),
  .ser_out(ser_out), .load_out(load_out)
);

// File: tb/seg_lcd_driver_test.sv
`timescale 1ns/1ps
module seg_lcd_driver_test;
  localparam int HALF = 160;
  localparam int INT_DIV = 4;
  localparam int TOTAL = 2 * HALF;
  localparam logic [1:0] C_LOW = 2'b00, C_MID = 2'b01, C_HIGH = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 0, ser_in = 0, load_in = 0, duty_mode = 0, div_sel = 0;
  logic osc_sel = 0, slave_mode = 0, ext_tick = 1, sync_in = 0;
  logic blank_in = 0, test_in = 0;
  logic [HALF-1:0] seg_out;
  logic [1:0] com_a, com_b;
  logic sync_out, ser_out, shift_out, load_out, blank_out, test_out;

  seg_lcd_driver #(.HALF(HALF), .INT_DIV(INT_DIV), .DIV_LOG(6)) uut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .load_in(load_in), .duty_mode(duty_mode), .div_sel(div_sel),
    .osc_sel(osc_sel), .slave_mode(slave_mode), .ext_tick(ext_tick),
    .sync_in(sync_in), .blank_in(blank_in), .test_in(test_in),
    .seg_out(seg_out), .com_a(com_a), .com_b(com_b), .sync_out(sync_out),
    .ser_out(ser_out), .shift_out(shift_out), .load_out(load_out),
    .blank_out(blank_out), .test_out(test_out)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic hist [0:1023];
  int nbits = 0;
  logic [HALF-1:0] la = '0, lb = '0;

  task automatic chk(input bit ok, input string req, input logic [HALF-1:0] act,
                     input logic [HALF-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // state index from commons: 0 A LOW, 1 A HIGH, 2 B LOW, 3 B HIGH
  function automatic int duty_idx(input logic [1:0] a, input logic [1:0] b);
    if (b == C_MID) return (a == C_HIGH) ? 1 : 0;
    return (b == C_HIGH) ? 3 : 2;
  endfunction

  function automatic logic [HALF-1:0] exp_seg(input bit duty, input logic [1:0] a,
      input logic [1:0] b, input bit blk, input bit tst);
    logic pol;
    logic [HALF-1:0] d;
    pol = (a == C_HIGH) || (b == C_HIGH);
    d = (duty && a == C_MID) ? lb : la;
    if (blk) d = '0;
    else if (tst) d = '1;
    return d ^ {HALF{pol}};
  endfunction

  task automatic shift_bit(input logic b, input bit chk_strobe);
    logic expv;
    @(negedge clk); shift_en = 1; ser_in = b;
    @(negedge clk); shift_en = 0;
    hist[nbits] = b; nbits++;
    if (chk_strobe) chk(shift_out == 1'b1, "R3 shift_out", HALF'(shift_out), HALF'(1));
    expv = (nbits >= TOTAL) ? hist[nbits - TOTAL] : 1'b0;
    chk(ser_out == expv, "R1 ser_out", HALF'(ser_out), HALF'(expv));
  endtask

  task automatic do_load();
    @(negedge clk); load_in = 1;
    @(negedge clk); load_in = 0;
    chk(load_out == 1'b1, "R3 load_out", HALF'(load_out), HALF'(1));
    for (int i = 0; i < HALF; i++) begin
      la[i] = hist[nbits - 1 - i];
      lb[i] = hist[nbits - 1 - HALF - i];
    end
    @(negedge clk);
  endtask

  task automatic wait_change(output int n);
    logic [3:0] prev;
    prev = {com_a, com_b};
    n = 0;
    do begin
      @(negedge clk); n++;
    end while ({com_a, com_b} == prev && n < 2000);
  endtask

  initial begin
    int n, idx, pidx;
    logic pol, ppol;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk(seg_out == '0, "R1 reset seg", seg_out, '0);
    chk(ser_out == 1'b0, "R1 reset ser_out", HALF'(ser_out), '0);
    rst = 0;

    // R1 serial delay and R2 load mapping
    for (int k = 0; k < 640; k++) shift_bit(1'($urandom() % 2), k == 0);
    do_load();
    chk(seg_out == exp_seg(0, com_a, com_b, 0, 0), "R2 static load", seg_out,
        exp_seg(0, com_a, com_b, 0, 0));
    for (int k = 0; k < 5; k++) shift_bit(1'($urandom() % 2), 0);
    chk(seg_out == exp_seg(0, com_a, com_b, 0, 0), "R2 no load unchanged", seg_out,
        exp_seg(0, com_a, com_b, 0, 0));

    // R4 / R5 static frames
    wait_change(n);
    ppol = (com_a == C_HIGH);
    for (int k = 0; k < 4; k++) begin
      wait_change(n);
      pol = (com_a == C_HIGH);
      chk(n == 64, "R4 static spacing", HALF'(n), HALF'(64));
      chk(com_a == com_b && com_a != C_MID, "R5 static commons", HALF'({com_a, com_b}), '0);
      chk(pol != ppol, "R5 polarity alternates", HALF'(pol), HALF'(~ppol));
      chk(seg_out == exp_seg(0, com_a, com_b, 0, 0), "R5 static seg", seg_out,
          exp_seg(0, com_a, com_b, 0, 0));
      chk(sync_out == 1'b0, "R10 no sync static", HALF'(sync_out), '0);
      ppol = pol;
    end

    // R6 / R7 / R10 half-duty
    duty_mode = 1;
    repeat (3) @(negedge clk);
    wait_change(n);
    pidx = duty_idx(com_a, com_b);
    for (int k = 0; k < 8; k++) begin
      wait_change(n);
      idx = duty_idx(com_a, com_b);
      chk(n == 64, "R4 duty spacing", HALF'(n), HALF'(64));
      chk(idx == (pidx + 1) % 4, "R6 phase order", HALF'(idx), HALF'((pidx + 1) % 4));
      chk((com_a == C_MID) != (com_b == C_MID), "R6 one common mid",
          HALF'({com_a, com_b}), '0);
      chk(seg_out == exp_seg(1, com_a, com_b, 0, 0), "R7 duty seg", seg_out,
          exp_seg(1, com_a, com_b, 0, 0));
      chk(sync_out == (idx == 0), "R10 sync_out", HALF'(sync_out), HALF'(idx == 0));
      pidx = idx;
    end

    // R8 / R9 overrides, random mix, then restore
    wait_change(n);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      blank_in = (k == 0) ? 1'b1 : 1'($urandom() % 2);
      test_in  = (k == 0) ? 1'b1 : ((k == 1) ? 1'b1 : 1'($urandom() % 2));
      if (k == 1) blank_in = 0;
      @(negedge clk);
      chk(blank_out == blank_in && test_out == test_in, "R3 override fwd",
          HALF'({blank_out, test_out}), HALF'({blank_in, test_in}));
      if (blank_in)
        chk(seg_out == exp_seg(1, com_a, com_b, 1, test_in), "R9 blank wins", seg_out,
            exp_seg(1, com_a, com_b, 1, test_in));
      else
        chk(seg_out == exp_seg(1, com_a, com_b, 0, test_in), "R8 test on", seg_out,
            exp_seg(1, com_a, com_b, 0, test_in));
    end
    @(negedge clk); blank_in = 0; test_in = 0;
    @(negedge clk);
    chk(seg_out == exp_seg(1, com_a, com_b, 0, 0), "R9 data restored", seg_out,
        exp_seg(1, com_a, com_b, 0, 0));

    // R4 divide by 128
    div_sel = 1;
    wait_change(n);
    wait_change(n);
    chk(n == 128, "R4 div128 spacing", HALF'(n), HALF'(128));
    div_sel = 0;

    // R4 internal tick
    osc_sel = 1; ext_tick = 0;
    wait_change(n);
    wait_change(n);
    wait_change(n);
    chk(n == 64 * INT_DIV, "R4 internal tick spacing", HALF'(n), HALF'(64 * INT_DIV));
    osc_sel = 0; ext_tick = 1;
    wait_change(n);

    // R11 master ignores sync
    do wait_change(n); while (duty_idx(com_a, com_b) == 0);
    repeat (5) @(negedge clk);
    idx = duty_idx(com_a, com_b);
    sync_in = 1; @(negedge clk); sync_in = 0;
    repeat (2) @(negedge clk);
    chk(duty_idx(com_a, com_b) == idx, "R11 master ignores sync",
        HALF'(duty_idx(com_a, com_b)), HALF'(idx));

    // R11 slave realigns
    slave_mode = 1;
    do wait_change(n); while (duty_idx(com_a, com_b) != 2);
    repeat (10) @(negedge clk);
    sync_in = 1; @(negedge clk); sync_in = 0;
    @(negedge clk);
    chk(duty_idx(com_a, com_b) == 0, "R11 slave realign", HALF'(duty_idx(com_a, com_b)), '0);
    wait_change(n);
    chk(n == 64, "R11 slave restart spacing", HALF'(n), HALF'(64));

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule